// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block receives 16-bit control words from a host over three wires: a serial data line, a shift clock and a latch strobe. Bits are taken least-significant first on each rising shift-clock edge. When the latch strobe falls, the two top bits of the accumulated word choose a destination. The rest of the word then loads either the level register (attenuation code, channel mute, de-emphasis enable) or the format register (audio bit order, word length, zero-detect period, de-emphasis rate, sample/PWM sync enable).

All three host lines are asynchronous to the block. They are resynchronised into a fast system clock domain, and edge detection happens there. Every decoded field is a registered output. A one-cycle pulse shows which register a committed word updated, so downstream audio logic can react to a new setting.

Top module: `serial_cfg_port`

## Requirements
- R1: A word is 16 bits sent least-significant bit first; one bit is taken from the data line on each rising edge of the shift clock.
- R2: Registers change only on a falling edge of the latch strobe; shifting bits and the rising edge of the latch leave every output unchanged.
- R3: A word with bits 15:14 = 00 loads the level register: bit 13 drives `deemph_en`, bit 12 drives `chan_mute`, and bits 10:0 drive `atten_code`.
- R4: A word with bits 15:14 = 01 loads the format register: bit 13 drives `audio_lsb_first`, bit 12 drives `word_18bit`, bit 5 drives `zd_long`, bits 3:2 drive `deemph_rate` (0 = 44.1 kHz, 1 = 48 kHz, 2 = 37.8 kHz, 3 = 32 kHz), and bit 1 drives `sync_en`.
- R5: A word with bit 15 set is discarded: no output changes and no write pulse is raised.
- R6: While `rst` is high, the level register holds 0x0400 (`atten_code` = 0x400, mute and de-emphasis off) and the format register holds 0x0000.
- R7: Each accepted word raises exactly one write pulse (`wr_level` or `wr_format`) for exactly one system clock, in the same cycle the register outputs take the new value. The two pulses are never high together.
- R8: Reserved bits (bit 11 of a level word; bits 11:6, 4 and 0 of a format word) affect no output.
- R9: If more than 16 bits are shifted before the latch falls, the last 16 bits shifted form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Asynchronous serial shift clock |
| sdata_in | input | 1 | Asynchronous serial data, LSB first |
| strobe_in | input | 1 | Asynchronous latch strobe; commits on its falling edge |
| deemph_en | output | 1 | De-emphasis enable |
| chan_mute | output | 1 | Channel mute |
| atten_code | output | 11 | Attenuation code |
| audio_lsb_first | output | 1 | Audio data arrives LSB first |
| word_18bit | output | 1 | Audio words are 18 bits (else 16) |
| zd_long | output | 1 | Long zero-detect period selected |
| deemph_rate | output | 2 | De-emphasis rate select |
| sync_en | output | 1 | Sample clock / PWM synchronisation enable |
| wr_level | output | 1 | One-cycle pulse: level register updated |
| wr_format | output | 1 | One-cycle pulse: format register updated |

## Verification
The assertions assume each host line holds every level for at least a few system clocks. That lets the two-flop synchronisers see each shift-clock high, each shift-clock low and each latch pulse as clean edges, with the data bit settled before the shift clock rises. The stimulus holds each phase for three to eight system clocks and changes data only while the shift clock is low. It raises the latch only after the last bit has been shifted, and lowers the latch only with the shift clock idle.

// File: rtl/scp_pkg.sv
package scp_pkg;

    parameter int WORD_W      = 16;
    parameter int ATT_W       = 11;
    parameter int RATE_W      = 2;
    parameter int SYNC_STAGES = 2;

    localparam int SEL_HI = WORD_W - 1;
    localparam int SEL_LO = WORD_W - 2;

    typedef enum logic [1:0] {
        SEL_LEVEL  = 2'b00,
        SEL_FORMAT = 2'b01,
        SEL_BAD_A  = 2'b10,
        SEL_BAD_B  = 2'b11
    } sel_e;

    typedef struct packed {
        logic             deemph_en;
        logic             mute;
        logic [ATT_W-1:0] code;
    } level_reg_t;

    typedef struct packed {
        logic              lsb_first;
        logic              len18;
        logic              zd_long;
        logic [RATE_W-1:0] rate;
        logic              sync_en;
    } format_reg_t;

    localparam level_reg_t LEVEL_RST = '{deemph_en: 1'b0, mute: 1'b0,
                                         code: ATT_W'(11'h400)};
    localparam format_reg_t FORMAT_RST = '0;

    function automatic sel_e word_sel(input logic [WORD_W-1:0] w);
        return sel_e'(w[SEL_HI:SEL_LO]);
    endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = scp_pkg::SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[STAGES-2:0], async_in[g]};
        end
        assign sync_out[g] = pipe[STAGES-1];
    end

endmodule

// File: rtl/scp_shifter.sv
module scp_shifter
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              sdata_s,
    input  logic              strobe_s,
    output logic [WORD_W-1:0] word,
    output logic              commit
);

    logic sclk_prev;
    logic strobe_prev;
    logic sclk_rise;
    logic strobe_fall;

    assign sclk_rise   = sclk_s & ~sclk_prev;
    assign strobe_fall = ~strobe_s & strobe_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev   <= 1'b0;
            strobe_prev <= 1'b0;
            word        <= '0;
            commit      <= 1'b0;
        end else begin
            sclk_prev   <= sclk_s;
            strobe_prev <= strobe_s;
            commit      <= strobe_fall;
            if (sclk_rise)
                word <= {sdata_s, word[WORD_W-1:1]};
        end
    end

endmodule

// File: rtl/scp_regs.sv
module scp_regs
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    input  logic              commit,
    output level_reg_t        level_q,
    output format_reg_t       format_q,
    output logic              wr_level,
    output logic              wr_format
);

    level_reg_t  level_d;
    format_reg_t format_d;
    logic        unused_rsvd;

    always_comb begin
        level_d.deemph_en = word[13];
        level_d.mute      = word[12];
        level_d.code      = word[ATT_W-1:0];
        format_d.lsb_first = word[13];
        format_d.len18     = word[12];
        format_d.zd_long   = word[5];
        format_d.rate      = word[3:2];
        format_d.sync_en   = word[1];
    end

    assign unused_rsvd = word[11];

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q   <= LEVEL_RST;
            format_q  <= FORMAT_RST;
            wr_level  <= 1'b0;
            wr_format <= 1'b0;
        end else begin
            wr_level  <= 1'b0;
            wr_format <= 1'b0;
            if (commit) begin
                case (word_sel(word))
                    SEL_LEVEL: begin
                        level_q  <= level_d;
                        wr_level <= 1'b1;
                    end
                    SEL_FORMAT: begin
                        format_q  <= format_d;
                        wr_format <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              sdata_in,
    input  logic              strobe_in,
    output logic              deemph_en,
    output logic              chan_mute,
    output logic [ATT_W-1:0]  atten_code,
    output logic              audio_lsb_first,
    output logic              word_18bit,
    output logic              zd_long,
    output logic [RATE_W-1:0] deemph_rate,
    output logic              sync_en,
    output logic              wr_level,
    output logic              wr_format
);

    logic [2:0]        synced;
    logic [WORD_W-1:0] shift_word;
    logic              commit;
    level_reg_t        level_q;
    format_reg_t       format_q;

    scp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({strobe_in, sdata_in, sclk_in}),
        .sync_out (synced)
    );

    scp_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (synced[0]),
        .sdata_s  (synced[1]),
        .strobe_s (synced[2]),
        .word     (shift_word),
        .commit   (commit)
    );

    scp_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .word      (shift_word),
        .commit    (commit),
        .level_q   (level_q),
        .format_q  (format_q),
        .wr_level  (wr_level),
        .wr_format (wr_format)
    );

    assign deemph_en       = level_q.deemph_en;
    assign chan_mute       = level_q.mute;
    assign atten_code      = level_q.code;
    assign audio_lsb_first = format_q.lsb_first;
    assign word_18bit      = format_q.len18;
    assign zd_long         = format_q.zd_long;
    assign deemph_rate     = format_q.rate;
    assign sync_en         = format_q.sync_en;

endmodule

// File: rtl/scp_checker.sv
module scp_checker
    import scp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              commit,
    input logic [WORD_W-1:0] shift_word,
    input logic              deemph_en,
    input logic              chan_mute,
    input logic [ATT_W-1:0]  atten_code,
    input logic              audio_lsb_first,
    input logic              word_18bit,
    input logic              zd_long,
    input logic [RATE_W-1:0] deemph_rate,
    input logic              sync_en,
    input logic              wr_level,
    input logic              wr_format
);

    p_pulse_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(wr_level && wr_format));

    p_level_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        wr_level |=> !wr_level);

    p_format_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        wr_format |=> !wr_format);

    p_level_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_level |-> $stable({deemph_en, chan_mute, atten_code}));

    p_format_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_format |-> $stable({audio_lsb_first, word_18bit, zd_long,
                                deemph_rate, sync_en}));

    p_level_sel_r3: assert property (@(posedge clk) disable iff (rst)
        (commit && shift_word[15:14] == 2'b00) |=> wr_level);

    p_format_sel_r4: assert property (@(posedge clk) disable iff (rst)
        (commit && shift_word[15:14] == 2'b01) |=> wr_format);

    p_drop_bad_r5: assert property (@(posedge clk) disable iff (rst)
        (commit && shift_word[15]) |=> !(wr_level || wr_format));

    p_reset_vals_r6: assert property (@(posedge clk)
        $past(rst) |-> (atten_code == 11'h400 && !deemph_en && !chan_mute &&
                        !audio_lsb_first && !word_18bit && !zd_long &&
                        deemph_rate == '0 && !sync_en));

endmodule

bind serial_cfg_port scp_checker i_scp_checker (
    .clk             (clk),
    .rst             (rst),
    .commit          (commit),
    .shift_word      (shift_word),
    .deemph_en       (deemph_en),
    .chan_mute       (chan_mute),
    .atten_code      (atten_code),
    .audio_lsb_first (audio_lsb_first),
    .word_18bit      (word_18bit),
    .zd_long         (zd_long),
    .deemph_rate     (deemph_rate),
    .sync_en         (sync_en),
    .wr_level        (wr_level),
    .wr_format       (wr_format)
);

// File: tb/test_serial_cfg_port.sv
module test_serial_cfg_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic        strobe_in = 1'b0;
    logic        deemph_en, chan_mute, audio_lsb_first, word_18bit;
    logic        zd_long, sync_en, wr_level, wr_format;
    logic [10:0] atten_code;
    logic [1:0]  deemph_rate;

    int n_cmp = 0;
    int n_bad = 0;
    int cnt_lvl = 0;
    int cnt_fmt = 0;
    int wide_pulse = 0;
    int both_pulse = 0;
    logic prev_lvl = 1'b0;
    logic prev_fmt = 1'b0;
    bit   done = 1'b0;

    logic [12:0] exp_lvl;
    logic [5:0]  exp_fmt;
    int exp_cnt_lvl = 0;
    int exp_cnt_fmt = 0;

    always #4 clk = ~clk;

    serial_cfg_port i_serial_cfg_port (
        .clk             (clk),
        .rst             (rst),
        .sclk_in         (sclk_in),
        .sdata_in        (sdata_in),
        .strobe_in       (strobe_in),
        .deemph_en       (deemph_en),
        .chan_mute       (chan_mute),
        .atten_code      (atten_code),
        .audio_lsb_first (audio_lsb_first),
        .word_18bit      (word_18bit),
        .zd_long         (zd_long),
        .deemph_rate     (deemph_rate),
        .sync_en         (sync_en),
        .wr_level        (wr_level),
        .wr_format       (wr_format)
    );

    // pulse monitor, sampled away from the active edge (R7)
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_level)  cnt_lvl++;
            if (wr_format) cnt_fmt++;
            if (wr_level && prev_lvl)  wide_pulse++;
            if (wr_format && prev_fmt) wide_pulse++;
            if (wr_level && wr_format) both_pulse++;
        end
        prev_lvl = wr_level;
        prev_fmt = wr_format;
    end

    task automatic check_vec(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        check_vec({tag, " level"}, 32'({deemph_en, chan_mute, atten_code}), 32'(exp_lvl));
        check_vec({tag, " format"}, 32'({audio_lsb_first, word_18bit, zd_long,
                                        deemph_rate, sync_en}), 32'(exp_fmt));
    endtask

    task automatic check_pulses(input string tag);
        check_vec({tag, " R7 level pulses"}, 32'(cnt_lvl), 32'(exp_cnt_lvl));
        check_vec({tag, " R7 format pulses"}, 32'(cnt_fmt), 32'(exp_cnt_fmt));
    endtask

    // expected register contents derived from the field layout (R3, R4, R8)
    function automatic void model_apply(input logic [15:0] w);
        if (w[15:14] == 2'b00) begin
            exp_lvl = {w[13], w[12], w[10:0]};
            exp_cnt_lvl++;
        end else if (w[15:14] == 2'b01) begin
            exp_fmt = {w[13], w[12], w[5], w[3:2], w[1]};
            exp_cnt_fmt++;
        end
    endfunction

    // LSB first, one bit per shift-clock rise (R1)
    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            sdata_in = v[i];
            repeat (3) @(negedge clk);
            sclk_in = 1'b1;
            repeat (5) @(negedge clk);
            sclk_in = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic latch_rise();
        strobe_in = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic latch_fall();
        strobe_in = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic write_word(input logic [15:0] w);
        shift_bits(32'(w), 16);
        latch_rise();
        latch_fall();
        model_apply(w);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        exp_lvl = 13'h0400;
        exp_fmt = 6'h00;
        check_outputs("R6 reset held");
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        exp_lvl = 13'h0400;
        exp_fmt = 6'h00;
        repeat (3) @(negedge clk);
        do_reset();
        check_outputs("R6 after reset release");
        check_pulses("R6");

        // R4: sweep every combination of the format fields, rate codes included
        for (int k = 0; k < 64; k++) begin
            logic [15:0] w;
            w = 16'h4000;
            w[13] = k[5]; w[12] = k[4]; w[5] = k[3];
            w[3:2] = k[2:1]; w[1] = k[0];
            write_word(w);
            check_outputs("R4 format sweep");
        end
        check_pulses("R4 sweep");

        // R3: de-emphasis/mute combinations across attenuation codes
        for (int c = 0; c < 10; c++) begin
            for (int m = 0; m < 4; m++) begin
                logic [15:0] w;
                logic [10:0] code;
                case (c)
                    0: code = 11'h000;
                    1: code = 11'h001;
                    2: code = 11'h200;
                    3: code = 11'h3FF;
                    4: code = 11'h400;
                    5: code = 11'h7FF;
                    default: code = 11'((c * 331 + 17) & 11'h7FF);
                endcase
                w = {2'b00, m[1], m[0], 1'b0, code};
                write_word(w);
                check_outputs("R3 level sweep");
            end
        end
        check_pulses("R3 sweep");

        // R8: reserved bits set change nothing beyond the fields
        write_word(16'h0800 | 16'h0155);
        check_outputs("R8 level reserved bit");
        write_word(16'h4000 | 16'h0FD1);
        check_outputs("R8 format reserved bits");

        // R5: bit 15 set, both select values, fields all ones
        write_word(16'h8000 | 16'h3FFF);
        check_outputs("R5 discard 10");
        write_word(16'hC000 | 16'h3FFF);
        check_outputs("R5 discard 11");
        check_pulses("R5");

        // R2: no change while shifting or on latch rise
        shift_bits(32'h0000_2123, 16);
        check_outputs("R2 after shift");
        latch_rise();
        check_outputs("R2 after latch rise");
        check_pulses("R2 before fall");
        latch_fall();
        model_apply(16'h2123);
        check_outputs("R2 after latch fall");
        check_pulses("R2 after fall");

        // R9: 20 bits shifted, last 16 form the word
        shift_bits(32'h0004_6A9F, 20);
        latch_rise();
        latch_fall();
        model_apply(16'h46A9);
        check_outputs("R9 overlong shift");

        // R1: bit order observed directly on a single set bit
        write_word(16'h0001);
        check_outputs("R1 lsb first level");
        write_word(16'h4002);
        check_outputs("R1 format single bit");

        // R7: pulse shape over the whole run
        check_pulses("R7 final");
        check_vec("R7 wide pulses", 32'(wide_pulse), 32'd0);
        check_vec("R7 simultaneous pulses", 32'(both_pulse), 32'd0);

        // R6: reset in mid-run restores defaults
        do_reset();
        check_outputs("R6 after mid-run reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule